// File: doc/BRIEF.md
# Compare-and-branch fusion detector

The block sits between an instruction queue and the decoders. It accepts pre-decoded instruction descriptors in program order and looks for a flag-setting compare, test or add that is followed directly by a conditional jump. When such a pair qualifies, the two descriptors leave as one compare-and-branch descriptor that fills a single output slot. Every other descriptor passes through unchanged and keeps its order.

One lookahead register holds a descriptor that might still pair. If the next accepted descriptor does not complete the pair, the held one leaves unfused first. If no descriptor arrives in the next cycle, it leaves unfused. A flush discards the held descriptor. A configuration input decides whether pairs whose first instruction runs in 64-bit mode may fuse at all. Input and output both use a valid/ready handshake, and output backpressure stalls input acceptance.

Top module: `cmpbr_fuser`

## Requirements
- R1: While reset is asserted and for the cycles the internal reset synchronizer takes to release, `out_valid` is 0. After that, with no stimulus, `in_ready` is 1 and `out_valid` stays 0.
- R2: Only two descriptors accepted in consecutive cycles, with nothing accepted between them, may fuse. An unrelated descriptor between a compare and a jump leaves all three unfused, in order.
- R3: The first descriptor of a pair must have class CMP (code 1), TEST (code 2) or ADD (code 3). The second must have class conditional jump (code 4). OTHER (code 0) never pairs, and a jump followed by a jump does not pair.
- R4: The first descriptor of a pair must have destination kind REG (code 1). Its source kind must be NONE (0), IMM (2) or MEM (3). A source of REG (1), an instruction-pointer-relative memory source MEMIP (4), or a destination that is not REG blocks fusion.
- R5: A TEST followed by a jump fuses for every 4-bit condition code, 0 through 15.
- R6: A CMP or ADD followed by a jump fuses only when the jump's condition code is between 2 and 7 inclusive. Code 1 or code 8 leaves both unfused.
- R7: When `cfg_fuse64` is 0, a first descriptor with `in_mode64`=1 never fuses. When `cfg_fuse64` is 1, or the mode bit is 0, the pair fuses normally.
- R8: A fused output has `out_fused`=1, `out_cls` set to the first class, and `out_cls2`=4. It takes its operand kinds and mode bit from the first descriptor, and its condition code and target from the jump. An unfused output has `out_fused`=0, `out_cls2`=0 and all of its own fields unchanged.
- R9: A held candidate that is not completed by the next accepted descriptor leaves unfused before that descriptor. The newer descriptor can then pair with the descriptor that follows it.
- R10: A held candidate leaves unfused after one cycle with no valid input. A jump that arrives later does not fuse with it.
- R11: While `flush` is 1, `in_ready` is 0 and the held descriptor is discarded without being output, so no pair forms across a flush.
- R12: While `out_valid` is 1 and `out_ready` is 0, the output descriptor holds steady. Under any backpressure pattern no descriptor is dropped, duplicated or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fuse64 | input | 1 | Allow fusion for 64-bit-mode pairs |
| flush | input | 1 | Discard the lookahead descriptor |
| in_valid | input | 1 | Input descriptor valid |
| in_ready | output | 1 | Block accepts the input descriptor |
| in_cls | input | 3 | Opcode class: 0 other, 1 CMP, 2 TEST, 3 ADD, 4 jump |
| in_dst_kind | input | 3 | Destination operand kind |
| in_src_kind | input | 3 | Source operand kind |
| in_cc | input | 4 | Condition code |
| in_mode64 | input | 1 | Descriptor executes in 64-bit mode |
| in_tgt | input | TGT_W | Jump target field |
| out_valid | output | 1 | Output descriptor valid |
| out_ready | input | 1 | Consumer accepts the output descriptor |
| out_fused | output | 1 | Output is a fused pair |
| out_cls | output | 3 | Class of the (first) instruction |
| out_cls2 | output | 3 | Class of the second instruction, 0 if single |
| out_dst_kind | output | 3 | Destination kind |
| out_src_kind | output | 3 | Source kind |
| out_cc | output | 4 | Condition code |
| out_mode64 | output | 1 | Mode bit |
| out_tgt | output | TGT_W | Target field |

## Verification
Pairs are driven with every eligible first class and with condition codes at both edges of the carry/zero range and just outside it. A wrong range bound therefore shows up as a missing or extra fused descriptor. Operand kinds and the mode/configuration combinations are each varied alone against a known-good pair, so each blocking rule can be isolated. Sequences containing an intervening descriptor, an idle cycle, a flush or two back-to-back candidates distinguish true adjacency from merely being held in the lookahead register. A mixed stream driven under periodic backpressure shows whether order and count survive stalls.

// File: rtl/fusion_pkg.sv
package fusion_pkg;

  typedef enum logic [2:0] {
    CLS_OTHER = 3'd0,
    CLS_CMP   = 3'd1,
    CLS_TEST  = 3'd2,
    CLS_ADD   = 3'd3,
    CLS_JCC   = 3'd4
  } opcls_e;

  typedef enum logic [2:0] {
    OPK_NONE  = 3'd0,
    OPK_REG   = 3'd1,
    OPK_IMM   = 3'd2,
    OPK_MEM   = 3'd3,
    OPK_MEMIP = 3'd4
  } opk_e;

  localparam int CC_W = 4;

  // descriptor as seen on the input side (target kept apart: width is a parameter)
  typedef struct packed {
    opcls_e          cls;
    opk_e            dstk;
    opk_e            srck;
    logic [CC_W-1:0] cc;
    logic            mode64;
  } desc_t;

  // descriptor as sent on the output side
  typedef struct packed {
    logic            fused;
    opcls_e          cls;
    opcls_e          cls2;
    opk_e            dstk;
    opk_e            srck;
    logic [CC_W-1:0] cc;
    logic            mode64;
  } odesc_t;

endpackage

// File: rtl/fuse_rst_sync.sv
module fuse_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shift_q[STAGES-1];

endmodule

// File: rtl/fuse_qualify.sv
// Decides whether one descriptor may open a fusion pair.
module fuse_qualify
  import fusion_pkg::*;
(
  input  desc_t d,
  input  logic  cfg_fuse64,
  output logic  cand
);

  logic cls_ok;
  logic dst_ok;
  logic src_ok;
  logic mode_ok;

  always_comb begin
    cls_ok  = (d.cls == CLS_CMP) || (d.cls == CLS_TEST) || (d.cls == CLS_ADD);
    dst_ok  = (d.dstk == OPK_REG);
    src_ok  = (d.srck == OPK_NONE) || (d.srck == OPK_IMM) || (d.srck == OPK_MEM);
    mode_ok = !d.mode64 || cfg_fuse64;
    cand    = cls_ok && dst_ok && src_ok && mode_ok;
  end

endmodule

// File: rtl/fuse_pair_match.sv
// Decides whether a following descriptor completes a pair with the held one.
module fuse_pair_match
  import fusion_pkg::*;
#(
  parameter int CC_LO = 2,
  parameter int CC_HI = 7
) (
  input  opcls_e          head_cls,
  input  opcls_e          nxt_cls,
  input  logic [CC_W-1:0] nxt_cc,
  output logic            hit
);

  localparam logic [CC_W-1:0] LO = CC_W'(CC_LO);
  localparam logic [CC_W-1:0] HI = CC_W'(CC_HI);

  logic is_jump;
  logic cz_only;

  always_comb begin
    is_jump = (nxt_cls == CLS_JCC);
    cz_only = (nxt_cc >= LO) && (nxt_cc <= HI);
    if (!is_jump)                 hit = 1'b0;
    else if (head_cls == CLS_TEST) hit = 1'b1;
    else                           hit = cz_only;
  end

endmodule

// File: rtl/fuse_pack.sv
// Builds the output descriptor: either a merged pair or a single passed through.
module fuse_pack
  import fusion_pkg::*;
#(
  parameter int TGT_W = 16
) (
  input  logic             fuse,
  input  desc_t            a,
  input  logic [TGT_W-1:0] a_tgt,
  input  logic [CC_W-1:0]  b_cc,
  input  logic [TGT_W-1:0] b_tgt,
  output odesc_t           o,
  output logic [TGT_W-1:0] o_tgt
);

  always_comb begin
    o.fused  = fuse;
    o.cls    = a.cls;
    o.cls2   = fuse ? CLS_JCC : CLS_OTHER;
    o.dstk   = a.dstk;
    o.srck   = a.srck;
    o.cc     = fuse ? b_cc : a.cc;
    o.mode64 = a.mode64;
    o_tgt    = fuse ? b_tgt : a_tgt;
  end

endmodule

// File: rtl/cmpbr_fuser.sv
module cmpbr_fuser
  import fusion_pkg::*;
#(
  parameter int TGT_W      = 16,
  parameter int CC_LO      = 2,
  parameter int CC_HI      = 7,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fuse64,
  input  logic             flush,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_cls,
  input  logic [2:0]       in_dst_kind,
  input  logic [2:0]       in_src_kind,
  input  logic [3:0]       in_cc,
  input  logic             in_mode64,
  input  logic [TGT_W-1:0] in_tgt,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_fused,
  output logic [2:0]       out_cls,
  output logic [2:0]       out_cls2,
  output logic [2:0]       out_dst_kind,
  output logic [2:0]       out_src_kind,
  output logic [3:0]       out_cc,
  output logic             out_mode64,
  output logic [TGT_W-1:0] out_tgt
);

  logic rst_ok;

  fuse_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ok)
  );

  // input descriptor
  desc_t in_d;
  always_comb begin
    in_d.cls    = opcls_e'(in_cls);
    in_d.dstk   = opk_e'(in_dst_kind);
    in_d.srck   = opk_e'(in_src_kind);
    in_d.cc     = in_cc;
    in_d.mode64 = in_mode64;
  end

  // lookahead register
  logic             hold_v_q, hold_v_n;
  logic             hold_c_q, hold_c_n;
  desc_t            hold_d_q, hold_d_n;
  logic [TGT_W-1:0] hold_t_q, hold_t_n;
  logic             hold_load;

  // output register
  logic             ob_v_q, ob_v_n;
  odesc_t           ob_d_q;
  logic [TGT_W-1:0] ob_t_q;
  logic             ob_load;

  logic in_cand;
  logic pair_hit_raw;
  logic pair_hit;
  logic out_free;
  logic do_fuse;

  fuse_qualify i_qualify (
    .d          (in_d),
    .cfg_fuse64 (cfg_fuse64),
    .cand       (in_cand)
  );

  fuse_pair_match #(.CC_LO(CC_LO), .CC_HI(CC_HI)) i_match (
    .head_cls (hold_d_q.cls),
    .nxt_cls  (in_d.cls),
    .nxt_cc   (in_d.cc),
    .hit      (pair_hit_raw)
  );

  assign pair_hit = hold_v_q && hold_c_q && pair_hit_raw;
  assign out_free = !ob_v_q || out_ready;
  assign in_ready = rst_ok && out_free && !flush;

  // next-state
  always_comb begin
    hold_v_n  = hold_v_q;
    hold_c_n  = hold_c_q;
    hold_d_n  = hold_d_q;
    hold_t_n  = hold_t_q;
    hold_load = 1'b0;
    ob_load   = 1'b0;
    do_fuse   = 1'b0;
    if (flush) begin
      hold_v_n = 1'b0;
    end else if (rst_ok && out_free) begin
      if (hold_v_q) begin
        ob_load = 1'b1;
        if (in_valid && pair_hit) begin
          do_fuse  = 1'b1;
          hold_v_n = 1'b0;
        end else if (in_valid) begin
          hold_load = 1'b1;
          hold_v_n  = 1'b1;
        end else begin
          hold_v_n = 1'b0;
        end
      end else if (in_valid) begin
        if (in_cand) begin
          hold_load = 1'b1;
          hold_v_n  = 1'b1;
        end else begin
          ob_load = 1'b1;
        end
      end
    end
    if (hold_load) begin
      hold_c_n = in_cand;
      hold_d_n = in_d;
      hold_t_n = in_tgt;
    end
    ob_v_n = ob_load || (ob_v_q && !out_ready);
  end

  // output packing
  desc_t            first_d;
  logic [TGT_W-1:0] first_t;
  odesc_t           pk_d;
  logic [TGT_W-1:0] pk_t;

  assign first_d = hold_v_q ? hold_d_q : in_d;
  assign first_t = hold_v_q ? hold_t_q : in_tgt;

  fuse_pack #(.TGT_W(TGT_W)) i_pack (
    .fuse  (do_fuse),
    .a     (first_d),
    .a_tgt (first_t),
    .b_cc  (in_d.cc),
    .b_tgt (in_tgt),
    .o     (pk_d),
    .o_tgt (pk_t)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      hold_v_q <= 1'b0;
      ob_v_q   <= 1'b0;
    end else begin
      hold_v_q <= hold_v_n;
      ob_v_q   <= ob_v_n;
    end
  end

  // data registers with explicit enables
  always_ff @(posedge clk) begin
    if (hold_load) begin
      hold_c_q <= hold_c_n;
      hold_d_q <= hold_d_n;
      hold_t_q <= hold_t_n;
    end
  end

  always_ff @(posedge clk) begin
    if (ob_load) begin
      ob_d_q <= pk_d;
      ob_t_q <= pk_t;
    end
  end

  assign out_valid    = ob_v_q;
  assign out_fused    = ob_d_q.fused;
  assign out_cls      = ob_d_q.cls;
  assign out_cls2     = ob_d_q.cls2;
  assign out_dst_kind = ob_d_q.dstk;
  assign out_src_kind = ob_d_q.srck;
  assign out_cc       = ob_d_q.cc;
  assign out_mode64   = ob_d_q.mode64;
  assign out_tgt      = ob_t_q;

endmodule

// File: rtl/cmpbr_fuser_chk.sv
module cmpbr_fuser_chk #(
  parameter int TGT_W = 16,
  parameter int CC_LO = 2,
  parameter int CC_HI = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_fuse64,
  input logic             flush,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_fused,
  input logic [2:0]       out_cls,
  input logic [2:0]       out_cls2,
  input logic [2:0]       out_dst_kind,
  input logic [2:0]       out_src_kind,
  input logic [3:0]       out_cc,
  input logic             out_mode64,
  input logic [TGT_W-1:0] out_tgt
);

  logic [TGT_W+17:0] out_bus;
  assign out_bus = {out_fused, out_cls, out_cls2, out_dst_kind, out_src_kind,
                    out_cc, out_mode64, out_tgt};

  AST_FUSED_CLASSES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused |-> out_cls2 == 3'd4 && out_cls >= 3'd1 && out_cls <= 3'd3); // R3

  AST_FUSED_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused |-> out_dst_kind == 3'd1 &&
      (out_src_kind == 3'd0 || out_src_kind == 3'd2 || out_src_kind == 3'd3)); // R4

  AST_CZ_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused && out_cls != 3'd2 |->
      out_cc >= 4'(CC_LO) && out_cc <= 4'(CC_HI)); // R6

  AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fused && out_mode64 |-> cfg_fuse64); // R7

  AST_SINGLE_NO_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_fused |-> out_cls2 == 3'd0); // R8

  AST_FLUSH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready); // R11

  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bus)); // R12

endmodule

bind cmpbr_fuser cmpbr_fuser_chk #(.TGT_W(TGT_W), .CC_LO(CC_LO), .CC_HI(CC_HI)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_fuse64   (cfg_fuse64),
  .flush        (flush),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_fused    (out_fused),
  .out_cls      (out_cls),
  .out_cls2     (out_cls2),
  .out_dst_kind (out_dst_kind),
  .out_src_kind (out_src_kind),
  .out_cc       (out_cc),
  .out_mode64   (out_mode64),
  .out_tgt      (out_tgt)
);

// File: tb/test_cmpbr_fuser.sv
`timescale 1ns/1ps
module test_cmpbr_fuser;

  localparam int TW = 16;
  localparam int RW = 1 + 3 + 3 + 3 + 3 + 4 + TW;

  localparam logic [2:0] C_OTH = 3'd0, C_CMP = 3'd1, C_TST = 3'd2, C_ADD = 3'd3, C_JCC = 3'd4;
  localparam logic [2:0] K_NON = 3'd0, K_REG = 3'd1, K_IMM = 3'd2, K_MEM = 3'd3, K_MIP = 3'd4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_fuse64;
  logic          flush;
  logic          in_valid;
  logic          in_ready;
  logic [2:0]    in_cls, in_dst_kind, in_src_kind;
  logic [3:0]    in_cc;
  logic          in_mode64;
  logic [TW-1:0] in_tgt;
  logic          out_valid;
  logic          out_ready;
  logic          out_fused;
  logic [2:0]    out_cls, out_cls2, out_dst_kind, out_src_kind;
  logic [3:0]    out_cc;
  logic          out_mode64;
  logic [TW-1:0] out_tgt;

  int total = 0;
  int bad   = 0;
  bit bp_en = 1'b0;
  int cyc   = 0;

  logic [RW-1:0] got_q[$];
  logic [RW-1:0] exp_q[$];

  always #4 clk = ~clk;

  cmpbr_fuser #(.TGT_W(TW)) i_cmpbr_fuser (
    .clk(clk), .rst_n(rst_n), .cfg_fuse64(cfg_fuse64), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls),
    .in_dst_kind(in_dst_kind), .in_src_kind(in_src_kind), .in_cc(in_cc),
    .in_mode64(in_mode64), .in_tgt(in_tgt),
    .out_valid(out_valid), .out_ready(out_ready), .out_fused(out_fused),
    .out_cls(out_cls), .out_cls2(out_cls2), .out_dst_kind(out_dst_kind),
    .out_src_kind(out_src_kind), .out_cc(out_cc), .out_mode64(out_mode64),
    .out_tgt(out_tgt)
  );

  // consumer: ready pattern, then sample after the edge settles
  always @(negedge clk) begin
    cyc++;
    out_ready = bp_en ? ((cyc % 3) != 1) : 1'b1;
    #1;
    if (rst_n && out_valid && out_ready)
      got_q.push_back({out_fused, out_cls, out_cls2, out_dst_kind, out_src_kind, out_cc, out_tgt});
  end

  function automatic logic [RW-1:0] rec(input logic f, input logic [2:0] c1, input logic [2:0] c2,
                                        input logic [2:0] dk, input logic [2:0] sk,
                                        input logic [3:0] cc, input logic [TW-1:0] t);
    return {f, c1, c2, dk, sk, cc, t};
  endfunction

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive one descriptor starting at a negedge; returns at the negedge after acceptance
  task automatic send(input logic [2:0] c, input logic [2:0] dk, input logic [2:0] sk,
                      input logic [3:0] cc, input logic m64, input logic [TW-1:0] t);
    bit acc;
    in_valid = 1'b1; in_cls = c; in_dst_kind = dk; in_src_kind = sk;
    in_cc = cc; in_mode64 = m64; in_tgt = t;
    do begin
      #2; acc = in_ready;
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic exp_one(input logic [2:0] c, input logic [2:0] dk, input logic [2:0] sk,
                         input logic [3:0] cc, input logic [TW-1:0] t);
    exp_q.push_back(rec(1'b0, c, C_OTH, dk, sk, cc, t));
  endtask

  task automatic exp_pair(input logic [2:0] c, input logic [2:0] dk, input logic [2:0] sk,
                          input logic [3:0] jcc, input logic [TW-1:0] jt);
    exp_q.push_back(rec(1'b1, c, C_JCC, dk, sk, jcc, jt));
  endtask

  // drain and compare the collected stream with the expected stream
  task automatic finish_scn(input string req);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    total++;
    if (got_q.size() != exp_q.size()) begin
      bad++;
      $display("FAIL %s: actual count=%0d expected count=%0d", req, got_q.size(), exp_q.size());
    end
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) check(req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic scn_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check_bit("R1", out_valid, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check_bit("R1", out_valid, 1'b0);
    check_bit("R1", in_ready, 1'b1);
    @(negedge clk);
  endtask

  task automatic scn_test_any();
    send(C_TST, K_REG, K_IMM, 4'd0, 1'b0, 16'h0011);
    send(C_JCC, K_NON, K_NON, 4'd15, 1'b0, 16'h0100);
    exp_pair(C_TST, K_REG, K_IMM, 4'd15, 16'h0100);
    send(C_TST, K_REG, K_NON, 4'd0, 1'b0, 16'h0012);
    send(C_JCC, K_NON, K_NON, 4'd0, 1'b0, 16'h0200);
    exp_pair(C_TST, K_REG, K_NON, 4'd0, 16'h0200);
    send(C_TST, K_REG, K_MEM, 4'd0, 1'b0, 16'h0013);
    send(C_JCC, K_NON, K_NON, 4'd9, 1'b0, 16'h0300);
    exp_pair(C_TST, K_REG, K_MEM, 4'd9, 16'h0300);
    finish_scn("R5");
  endtask

  task automatic scn_cz_range();
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'h1000);
    send(C_JCC, K_NON, K_NON, 4'd2, 1'b0, 16'h1002);
    exp_pair(C_CMP, K_REG, K_IMM, 4'd2, 16'h1002);
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'h1000);
    send(C_JCC, K_NON, K_NON, 4'd7, 1'b0, 16'h1007);
    exp_pair(C_CMP, K_REG, K_IMM, 4'd7, 16'h1007);
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'h1000);
    send(C_JCC, K_NON, K_NON, 4'd1, 1'b0, 16'h1001);
    exp_one(C_CMP, K_REG, K_IMM, 4'd0, 16'h1000);
    exp_one(C_JCC, K_NON, K_NON, 4'd1, 16'h1001);
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'h1000);
    send(C_JCC, K_NON, K_NON, 4'd8, 1'b0, 16'h1008);
    exp_one(C_CMP, K_REG, K_IMM, 4'd0, 16'h1000);
    exp_one(C_JCC, K_NON, K_NON, 4'd8, 16'h1008);
    send(C_ADD, K_REG, K_MEM, 4'd0, 1'b0, 16'h2000);
    send(C_JCC, K_NON, K_NON, 4'd3, 1'b0, 16'h2003);
    exp_pair(C_ADD, K_REG, K_MEM, 4'd3, 16'h2003);
    send(C_ADD, K_REG, K_MEM, 4'd0, 1'b0, 16'h2000);
    send(C_JCC, K_NON, K_NON, 4'd9, 1'b0, 16'h2009);
    exp_one(C_ADD, K_REG, K_MEM, 4'd0, 16'h2000);
    exp_one(C_JCC, K_NON, K_NON, 4'd9, 16'h2009);
    finish_scn("R6");
  endtask

  task automatic scn_classes();
    send(C_OTH, K_REG, K_IMM, 4'd0, 1'b0, 16'h3000);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'h3001);
    exp_one(C_OTH, K_REG, K_IMM, 4'd0, 16'h3000);
    exp_one(C_JCC, K_NON, K_NON, 4'd4, 16'h3001);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'h3002);
    send(C_JCC, K_NON, K_NON, 4'd5, 1'b0, 16'h3003);
    exp_one(C_JCC, K_NON, K_NON, 4'd4, 16'h3002);
    exp_one(C_JCC, K_NON, K_NON, 4'd5, 16'h3003);
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'h3004);
    send(C_OTH, K_REG, K_REG, 4'd4, 1'b0, 16'h3005);
    exp_one(C_CMP, K_REG, K_IMM, 4'd0, 16'h3004);
    exp_one(C_OTH, K_REG, K_REG, 4'd4, 16'h3005);
    finish_scn("R3");
  endtask

  task automatic scn_operands();
    send(C_CMP, K_MEM, K_IMM, 4'd0, 1'b0, 16'h4000);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'h4001);
    exp_one(C_CMP, K_MEM, K_IMM, 4'd0, 16'h4000);
    exp_one(C_JCC, K_NON, K_NON, 4'd4, 16'h4001);
    send(C_CMP, K_REG, K_MIP, 4'd0, 1'b0, 16'h4002);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'h4003);
    exp_one(C_CMP, K_REG, K_MIP, 4'd0, 16'h4002);
    exp_one(C_JCC, K_NON, K_NON, 4'd4, 16'h4003);
    send(C_TST, K_REG, K_REG, 4'd0, 1'b0, 16'h4004);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'h4005);
    exp_one(C_TST, K_REG, K_REG, 4'd0, 16'h4004);
    exp_one(C_JCC, K_NON, K_NON, 4'd4, 16'h4005);
    send(C_CMP, K_REG, K_MEM, 4'd0, 1'b0, 16'h4006);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'h4007);
    exp_pair(C_CMP, K_REG, K_MEM, 4'd4, 16'h4007);
    finish_scn("R4");
  endtask

  task automatic scn_packing();
    send(C_CMP, K_REG, K_MEM, 4'd12, 1'b0, 16'h5555);
    send(C_JCC, K_IMM, K_IMM, 4'd5, 1'b0, 16'hBEEF);
    exp_pair(C_CMP, K_REG, K_MEM, 4'd5, 16'hBEEF);
    send(C_OTH, K_MEM, K_MIP, 4'd11, 1'b0, 16'h1234);
    exp_one(C_OTH, K_MEM, K_MIP, 4'd11, 16'h1234);
    finish_scn("R8");
  endtask

  task automatic scn_adjacent();
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'h6000);
    send(C_OTH, K_REG, K_REG, 4'd0, 1'b0, 16'h6001);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'h6002);
    exp_one(C_CMP, K_REG, K_IMM, 4'd0, 16'h6000);
    exp_one(C_OTH, K_REG, K_REG, 4'd0, 16'h6001);
    exp_one(C_JCC, K_NON, K_NON, 4'd4, 16'h6002);
    finish_scn("R2");
  endtask

  task automatic scn_back_to_back();
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'h7000);
    send(C_TST, K_REG, K_IMM, 4'd0, 1'b0, 16'h7001);
    send(C_JCC, K_NON, K_NON, 4'd13, 1'b0, 16'h7002);
    exp_one(C_CMP, K_REG, K_IMM, 4'd0, 16'h7000);
    exp_pair(C_TST, K_REG, K_IMM, 4'd13, 16'h7002);
    finish_scn("R9");
  endtask

  task automatic scn_idle();
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'h8000);
    @(negedge clk);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'h8001);
    exp_one(C_CMP, K_REG, K_IMM, 4'd0, 16'h8000);
    exp_one(C_JCC, K_NON, K_NON, 4'd4, 16'h8001);
    finish_scn("R10");
  endtask

  task automatic scn_mode();
    cfg_fuse64 = 1'b0;
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b1, 16'h9000);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b1, 16'h9001);
    exp_one(C_CMP, K_REG, K_IMM, 4'd0, 16'h9000);
    exp_one(C_JCC, K_NON, K_NON, 4'd4, 16'h9001);
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'h9002);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'h9003);
    exp_pair(C_CMP, K_REG, K_IMM, 4'd4, 16'h9003);
    finish_scn("R7");
    cfg_fuse64 = 1'b1;
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b1, 16'h9004);
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b1, 16'h9005);
    exp_pair(C_CMP, K_REG, K_IMM, 4'd4, 16'h9005);
    finish_scn("R7");
  endtask

  task automatic scn_flush();
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'hA000);
    flush = 1'b1;
    #2;
    check_bit("R11", in_ready, 1'b0);
    @(negedge clk);
    flush = 1'b0;
    send(C_JCC, K_NON, K_NON, 4'd4, 1'b0, 16'hA001);
    exp_one(C_JCC, K_NON, K_NON, 4'd4, 16'hA001);
    finish_scn("R11");
  endtask

  task automatic scn_backpressure();
    bp_en = 1'b1;
    send(C_TST, K_REG, K_IMM, 4'd0, 1'b0, 16'hB000);
    send(C_JCC, K_NON, K_NON, 4'd14, 1'b0, 16'hB001);
    send(C_OTH, K_REG, K_REG, 4'd0, 1'b0, 16'hB002);
    send(C_CMP, K_REG, K_IMM, 4'd0, 1'b0, 16'hB003);
    send(C_JCC, K_NON, K_NON, 4'd9, 1'b0, 16'hB004);
    send(C_CMP, K_REG, K_MEM, 4'd0, 1'b0, 16'hB005);
    send(C_JCC, K_NON, K_NON, 4'd3, 1'b0, 16'hB006);
    send(C_OTH, K_NON, K_NON, 4'd1, 1'b0, 16'hB007);
    send(C_ADD, K_REG, K_IMM, 4'd0, 1'b0, 16'hB008);
    exp_pair(C_TST, K_REG, K_IMM, 4'd14, 16'hB001);
    exp_one(C_OTH, K_REG, K_REG, 4'd0, 16'hB002);
    exp_one(C_CMP, K_REG, K_IMM, 4'd0, 16'hB003);
    exp_one(C_JCC, K_NON, K_NON, 4'd9, 16'hB004);
    exp_pair(C_CMP, K_REG, K_MEM, 4'd3, 16'hB006);
    exp_one(C_OTH, K_NON, K_NON, 4'd1, 16'hB007);
    exp_one(C_ADD, K_REG, K_IMM, 4'd0, 16'hB008);
    finish_scn("R12");
    bp_en = 1'b0;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_fuse64 = 1'b1; flush = 1'b0; in_valid = 1'b0;
    in_cls = '0; in_dst_kind = '0; in_src_kind = '0; in_cc = '0; in_mode64 = 1'b0; in_tgt = '0;
    out_ready = 1'b1;
    @(negedge clk);
    scn_reset();
    scn_test_any();
    scn_cz_range();
    scn_classes();
    scn_operands();
    scn_packing();
    scn_adjacent();
    scn_back_to_back();
    scn_idle();
    scn_mode();
    scn_flush();
    scn_backpressure();
    summary();
  end

endmodule